// File: doc/BRIEF.md
# Multi-Channel DMA Control and Status Register File

This block is the register file that a DMA engine of up to sixteen channels shares. Three shared registers carry, for every channel, a freeze control and a reset request (control register), a completion flag and its interrupt enable (completion register), and an error flag together with an error-type bit (error register). Each shared register can be written three ways. A plain write replaces it. A write to its set alias ORs bits in. A write to its clear alias removes bits. Software can therefore acknowledge one channel without a read-modify-write race against the others.

Each channel also owns a small window of registers. It holds the next-descriptor address that the channel datapath fetches from, the current buffer address that the datapath reports back, and a semaphore counter. Software adds to the semaphore and the datapath decrements it. Channels report completion, termination and bus errors as one-cycle event pulses. The block raises one interrupt line per channel. It also holds back a requested channel reset while that channel is in its read-flush state.

The register port is a plain single-cycle slave. A write takes effect at the clock edge where `reg_wr` is high. `reg_rdata` is a combinational function of `reg_addr` and the current register state. There is no back-pressure on either side. Event inputs are sampled on every clock edge and never stall.

Top module: `dma_chan_csr`

## Requirements
- R1: Register map: control register at 0x000, completion at 0x010, error at 0x020. For each of them the set alias is at +0x4 and the clear alias at +0x8. A plain write at the base offset replaces the whole 32-bit value. A read at the base offset returns the value, and reads of aliases or unmapped addresses return 0.
- R2: A write to a set alias sets exactly the bits written as 1. A write to a clear alias clears exactly the bits written as 1. All other bits keep their value.
- R3: A pulse on `ev_done[i]` sets completion bit i, which stays set until software clears it. A completion event wins over a software clear or plain write in the same cycle. Bits 31:16 of the completion register are interrupt enables, changed only by software.
- R4: Error register bit i is the error flag and bit 16+i the error type. A bus-error pulse sets both (code 2). A terminate pulse sets the flag and clears the type bit (code 1). If both arrive in the same cycle, the bus error wins.
- R5: `irq[i]` is high while completion bit i and enable bit 16+i are both set, or while error flag bit i is set.
- R6: `ch_freeze[i]` follows control register bit i.
- R7: Setting control bit 16+i requests a reset of channel i. When the channel is not flushing, `ch_reset[i]` is high for exactly one cycle, the cycle after the write, and the request bit then reads 0.
- R8: While `ch_state` of channel i equals 4'h8 (read-flush), `ch_reset[i]` stays low and the request stays pending. It fires in the first cycle the state differs.
- R9: Register 0x110 + i*0x70 is channel i's next-descriptor address. It is read/write, 32 bits, and drives `ch_next_desc` slice i.
- R10: Register 0x130 + i*0x70 reads channel i's `ch_cur_buf` input. Writes to it have no effect.
- R11: Register 0x140 + i*0x70 holds channel i's 8-bit semaphore in bits 7:0. A write adds `reg_wdata[7:0]` to it, saturating at 255. A `sem_dec[i]` pulse subtracts one when the count is non-zero. The count drives `ch_sem_count` slice i.
- R12: After reset every register, `irq`, `ch_freeze` and `ch_reset` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| ev_done | input | 16 | Per-channel completion pulse |
| ev_term | input | 16 | Per-channel terminate pulse |
| ev_bus_err | input | 16 | Per-channel bus-error pulse |
| sem_dec | input | 16 | Per-channel semaphore decrement pulse |
| ch_state | input | 64 | Per-channel 4-bit datapath state |
| ch_cur_buf | input | 512 | Per-channel current buffer address |
| ch_next_desc | output | 512 | Per-channel next-descriptor address |
| ch_sem_count | output | 128 | Per-channel semaphore count |
| ch_freeze | output | 16 | Per-channel freeze |
| ch_reset | output | 16 | Per-channel one-cycle reset pulse |
| irq | output | 16 | Per-channel interrupt |

## Verification
The assertions check four things on every cycle:
- a completion or bus-error pulse is visible in the next cycle, as a completion flag or as an interrupt;
- no reset pulse reaches a channel that is in read-flush;
- a reset pulse never lasts two cycles;
- freeze outputs move only on a register write.

The bench's scenarios cover the behaviour that depends on sequences or data:
- alias arithmetic against a reference model under random writes racing random events;
- error-code precedence between terminate and bus-error pulses;
- semaphore saturation and the floor at zero;
- a reset that stays pending through a flush and then fires once.

// File: rtl/dmacsr_pkg.sv
package dmacsr_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned NUM_CH   = 16;
  localparam int unsigned STATE_W  = 4;
  localparam int unsigned SEM_W    = 8;

  // shared registers and their alias displacement
  localparam int unsigned OFS_CTRL  = 'h000;
  localparam int unsigned OFS_DONE  = 'h010;
  localparam int unsigned OFS_ERR   = 'h020;
  localparam int unsigned ALIAS_SET = 'h4;
  localparam int unsigned ALIAS_CLR = 'h8;

  // per-channel window
  localparam int unsigned WIN_NXT    = 'h110;
  localparam int unsigned WIN_BUF    = 'h130;
  localparam int unsigned WIN_SEM    = 'h140;
  localparam int unsigned WIN_STRIDE = 'h070;

  localparam logic [STATE_W-1:0] STATE_FLUSH = 4'h8;

  typedef enum logic [1:0] {WK_NONE, WK_PLAIN, WK_SET, WK_CLR} wr_kind_e;
endpackage

// File: rtl/dmacsr_alias_reg.sv
module dmacsr_alias_reg
  import dmacsr_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  wr_kind_e     kind,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_set,
  input  logic [W-1:0] hw_clr,
  output logic [W-1:0] q
);
  logic [W-1:0] sw_next;

  always_comb begin
    unique case (kind)
      WK_PLAIN: sw_next = wdata;
      WK_SET:   sw_next = q | wdata;
      WK_CLR:   sw_next = q & ~wdata;
      default:  sw_next = q;
    endcase
  end

  // hardware events take precedence over software in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (sw_next & ~hw_clr) | hw_set;
  end
endmodule

// File: rtl/dmacsr_chan_regs.sv
module dmacsr_chan_regs
  import dmacsr_pkg::*;
#(
  parameter int unsigned CH   = 0,
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned SW   = SEM_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          sem_dec,
  input  logic [DW-1:0] cur_buf,
  output logic [DW-1:0] next_desc,
  output logic [SW-1:0] sem_count,
  output logic [DW-1:0] rd_data
);
  localparam logic [AW-1:0] A_NXT = AW'(WIN_NXT + CH * WIN_STRIDE);
  localparam logic [AW-1:0] A_BUF = AW'(WIN_BUF + CH * WIN_STRIDE);
  localparam logic [AW-1:0] A_SEM = AW'(WIN_SEM + CH * WIN_STRIDE);

  logic          hit_nxt, hit_buf, hit_sem;
  logic [SW:0]   sem_sum;
  logic [SW:0]   sem_dec_sum;

  assign hit_nxt = (reg_addr == A_NXT);
  assign hit_buf = (reg_addr == A_BUF);
  assign hit_sem = (reg_addr == A_SEM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 next_desc <= '0;
    else if (reg_wr && hit_nxt) next_desc <= reg_wdata;
  end

  // add first, then take the decrement, then saturate
  always_comb begin
    sem_sum     = {1'b0, sem_count} + ((reg_wr && hit_sem) ? {1'b0, reg_wdata[SW-1:0]} : '0);
    sem_dec_sum = (sem_dec && (sem_sum != '0)) ? sem_sum - 1'b1 : sem_sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               sem_count <= '0;
    else if (sem_dec_sum[SW]) sem_count <= '1;
    else                      sem_count <= sem_dec_sum[SW-1:0];
  end

  always_comb begin
    rd_data = '0;
    if (hit_nxt) rd_data = next_desc;
    if (hit_buf) rd_data = cur_buf;
    if (hit_sem) rd_data = DW'(sem_count);
  end
endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
  import dmacsr_pkg::*;
#(
  parameter int unsigned N_CH = NUM_CH,
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned STW  = STATE_W,
  parameter int unsigned SW   = SEM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [N_CH-1:0]   ev_done,
  input  logic [N_CH-1:0]   ev_term,
  input  logic [N_CH-1:0]   ev_bus_err,
  input  logic [N_CH-1:0]   sem_dec,
  input  logic [N_CH*STW-1:0] ch_state,
  input  logic [N_CH*DW-1:0]  ch_cur_buf,
  output logic [N_CH*DW-1:0]  ch_next_desc,
  output logic [N_CH*SW-1:0]  ch_sem_count,
  output logic [N_CH-1:0]   ch_freeze,
  output logic [N_CH-1:0]   ch_reset,
  output logic [N_CH-1:0]   irq
);
  localparam int unsigned HALF = DW / 2;

  function automatic wr_kind_e kind_of(input int unsigned base);
    if (!reg_wr)                          return WK_NONE;
    if (reg_addr == AW'(base))             return WK_PLAIN;
    if (reg_addr == AW'(base + ALIAS_SET)) return WK_SET;
    if (reg_addr == AW'(base + ALIAS_CLR)) return WK_CLR;
    return WK_NONE;
  endfunction

  wr_kind_e        k_ctrl, k_done, k_err;
  logic [DW-1:0]   ctrl_q, done_q, err_q;
  logic [DW-1:0]   err_set, err_clr;
  logic [N_CH-1:0] flushing;
  logic [N_CH-1:0] rst_req;
  logic [DW-1:0]   ch_rd [N_CH];
  logic [DW-1:0]   win_rd;

  assign k_ctrl = kind_of(OFS_CTRL);
  assign k_done = kind_of(OFS_DONE);
  assign k_err  = kind_of(OFS_ERR);

  // bus error: flag + type; terminate alone: flag, type cleared
  assign err_set = DW'(ev_term | ev_bus_err) | (DW'(ev_bus_err) << HALF);
  assign err_clr = DW'(ev_term & ~ev_bus_err) << HALF;

  dmacsr_alias_reg #(.W(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .kind(k_ctrl), .wdata(reg_wdata),
    .hw_set('0), .hw_clr(DW'(ch_reset) << HALF), .q(ctrl_q)
  );

  dmacsr_alias_reg #(.W(DW)) u_done (
    .clk(clk), .rst_n(rst_n), .kind(k_done), .wdata(reg_wdata),
    .hw_set(DW'(ev_done)), .hw_clr('0), .q(done_q)
  );

  dmacsr_alias_reg #(.W(DW)) u_err (
    .clk(clk), .rst_n(rst_n), .kind(k_err), .wdata(reg_wdata),
    .hw_set(err_set), .hw_clr(err_clr), .q(err_q)
  );

  assign rst_req   = ctrl_q[HALF +: N_CH];
  assign ch_freeze = ctrl_q[N_CH-1:0];
  assign ch_reset  = rst_req & ~flushing;
  assign irq       = (done_q[N_CH-1:0] & done_q[HALF +: N_CH]) | err_q[N_CH-1:0];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign flushing[c] = (ch_state[c*STW +: STW] == STATE_FLUSH);

    dmacsr_chan_regs #(.CH(c), .AW(AW), .DW(DW), .SW(SW)) u_win (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .sem_dec(sem_dec[c]),
      .cur_buf(ch_cur_buf[c*DW +: DW]),
      .next_desc(ch_next_desc[c*DW +: DW]),
      .sem_count(ch_sem_count[c*SW +: SW]),
      .rd_data(ch_rd[c])
    );
  end

  always_comb begin
    win_rd = '0;
    for (int c = 0; c < N_CH; c++) win_rd = win_rd | ch_rd[c];
  end

  always_comb begin
    if      (reg_addr == AW'(OFS_CTRL)) reg_rdata = ctrl_q;
    else if (reg_addr == AW'(OFS_DONE)) reg_rdata = done_q;
    else if (reg_addr == AW'(OFS_ERR))  reg_rdata = err_q;
    else                                reg_rdata = win_rd;
  end
endmodule

// File: rtl/dma_chan_csr_chk.sv
module dma_chan_csr_chk
  import dmacsr_pkg::*;
#(
  parameter int unsigned N_CH = NUM_CH,
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned STW  = STATE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [N_CH-1:0]   ev_done,
  input logic [N_CH-1:0]   ev_bus_err,
  input logic [N_CH*STW-1:0] ch_state,
  input logic [N_CH-1:0]   ch_reset,
  input logic [N_CH-1:0]   ch_freeze,
  input logic [N_CH-1:0]   irq,
  input logic [DW-1:0]     done_q
);
  assert_done_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done != '0) |=> ((done_q[N_CH-1:0] & $past(ev_done)) == $past(ev_done)));

  assert_buserr_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bus_err != '0) |=> ((irq & $past(ev_bus_err)) == $past(ev_bus_err)));

  assert_freeze_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(ch_freeze));

  assert_reset_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_reset != '0) |=> ((ch_reset & $past(ch_reset)) == '0));

  for (genvar c = 0; c < N_CH; c++) begin : g_defer
    assert_reset_defer_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ch_reset[c] |-> (ch_state[c*STW +: STW] != STATE_FLUSH));
  end
endmodule

bind dma_chan_csr dma_chan_csr_chk #(.N_CH(N_CH), .DW(DW), .STW(STW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .ev_done(ev_done),
  .ev_bus_err(ev_bus_err), .ch_state(ch_state), .ch_reset(ch_reset),
  .ch_freeze(ch_freeze), .irq(irq), .done_q(done_q)
);

// File: tb/test_dma_chan_csr.sv
module test_dma_chan_csr;
  localparam int NC = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [11:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NC-1:0] ev_done = '0, ev_term = '0, ev_bus_err = '0, sem_dec = '0;
  logic [NC*4-1:0]  ch_state = '0;
  logic [NC*32-1:0] ch_cur_buf = '0;
  logic [NC*32-1:0] ch_next_desc;
  logic [NC*8-1:0]  ch_sem_count;
  logic [NC-1:0] ch_freeze, ch_reset, irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dma_chan_csr i_dma_chan_csr (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_done(ev_done),
    .ev_term(ev_term), .ev_bus_err(ev_bus_err), .sem_dec(sem_dec),
    .ch_state(ch_state), .ch_cur_buf(ch_cur_buf), .ch_next_desc(ch_next_desc),
    .ch_sem_count(ch_sem_count), .ch_freeze(ch_freeze), .ch_reset(ch_reset),
    .irq(irq)
  );

  function automatic logic [11:0] win(input int base, input int ch);
    return 12'(base + ch * 'h70);
  endfunction

  function automatic logic [31:0] alias_model(input logic [31:0] cur, input int op,
                                              input logic [31:0] d);
    case (op)
      0:       return d;
      1:       return cur | d;
      default: return cur & ~d;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input int kind, input logic [NC-1:0] m);
    @(negedge clk);
    case (kind)
      0: ev_done = m;
      1: ev_term = m;
      2: ev_bus_err = m;
      default: sem_dec = m;
    endcase
    @(negedge clk);
    ev_done = '0; ev_term = '0; ev_bus_err = '0; sem_dec = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r, model;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    rd(12'h000, r); chk("R12 ctrl", r, 0);
    rd(12'h010, r); chk("R12 done", r, 0);
    rd(12'h020, r); chk("R12 err", r, 0);
    rd(win(12'h140, 5), r); chk("R12 sem", r, 0);
    chk("R12 outputs", {irq, ch_freeze, ch_reset}, 0);

    // R1 plain write, alias reads zero, unmapped zero
    wr(12'h010, 32'hA5A5_0000);
    rd(12'h010, r); chk("R1 plain", r, 32'hA5A5_0000);
    rd(12'h014, r); chk("R1 alias read", r, 0);
    rd(12'h7FC, r); chk("R1 unmapped", r, 0);
    wr(12'h010, 32'h0);

    // R2/R3 random alias ops racing completion events against a model
    model = 0;
    for (int it = 0; it < 150; it++) begin
      int op = int'($urandom % 3);
      logic [31:0] d = $urandom;
      logic [NC-1:0] ev = (($urandom % 4) == 0) ? NC'($urandom) : '0;
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 12'(32'h010 + op * 4); reg_wdata = d; ev_done = ev;
      @(negedge clk);
      reg_wr = 1'b0; ev_done = '0;
      model = alias_model(model, op, d) | 32'(ev);
      rd(12'h010, r); chk("R2 R3 alias/event", r, model);
      chk("R5 irq done&en", 32'(irq), 32'(model[15:0] & model[31:16]));
    end
    wr(12'h010, 32'h0);

    // R3 event wins over same-cycle clear
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 12'h018; reg_wdata = 32'hFFFF_FFFF; ev_done = 16'h0040;
    @(negedge clk);
    reg_wr = 1'b0; ev_done = '0;
    rd(12'h010, r); chk("R3 event beats clear", r, 32'h0000_0040);
    wr(12'h010, 32'h0);

    // R4 error codes
    pulse(1, 16'h0008);
    rd(12'h020, r); chk("R4 terminate", r, 32'h0000_0008);
    pulse(2, 16'h0020);
    rd(12'h020, r); chk("R4 bus error", r, 32'h0020_0028);
    @(negedge clk); ev_term = 16'h0080; ev_bus_err = 16'h0080;
    @(negedge clk); ev_term = '0; ev_bus_err = '0;
    rd(12'h020, r); chk("R4 both same cycle", r, 32'h00A0_00A8);
    pulse(1, 16'h0020);
    rd(12'h020, r); chk("R4 terminate clears type", r, 32'h0080_00A8);
    chk("R5 irq from error", 32'(irq), 32'h0000_00A8);
    wr(12'h028, 32'hFFFF_FFFF);
    rd(12'h020, r); chk("R2 clear alias err", r, 0);
    chk("R5 irq cleared", 32'(irq), 0);

    // R5 enable gating
    wr(12'h014, 32'h0004_0000);
    pulse(0, 16'h0014);
    chk("R5 enabled and masked", 32'(irq), 32'h0000_0004);
    wr(12'h010, 32'h0);

    // R6 freeze
    wr(12'h004, 32'h0000_0201);
    chk("R6 freeze", 32'(ch_freeze), 32'h0000_0201);
    wr(12'h008, 32'h0000_0001);
    chk("R6 freeze clr", 32'(ch_freeze), 32'h0000_0200);

    // R7 immediate reset pulse
    wr(12'h004, 32'h0002_0000);
    chk("R7 pulse", 32'(ch_reset), 32'h0000_0002);
    @(negedge clk);
    chk("R7 one cycle", 32'(ch_reset), 0);
    rd(12'h000, r); chk("R7 self clear", r, 32'h0000_0200);

    // R8 deferred reset during flush
    ch_state[6*4 +: 4] = 4'h8;
    wr(12'h004, 32'h0040_0000);
    chk("R8 held", 32'(ch_reset), 0);
    repeat (3) @(negedge clk);
    chk("R8 still held", 32'(ch_reset), 0);
    rd(12'h000, r); chk("R8 pending", r, 32'h0040_0200);
    ch_state[6*4 +: 4] = 4'h3;
    #1;
    chk("R8 fires on exit", 32'(ch_reset), 32'h0000_0040);
    @(negedge clk);
    chk("R8 single pulse", 32'(ch_reset), 0);
    rd(12'h000, r); chk("R8 cleared", r, 32'h0000_0200);

    // R9 next descriptor window
    wr(win(12'h110, 0), 32'h1234_5678);
    wr(win(12'h110, 15), 32'hCAFE_F00D);
    rd(win(12'h110, 15), r); chk("R9 read ch15", r, 32'hCAFE_F00D);
    chk("R9 out ch0", ch_next_desc[31:0], 32'h1234_5678);
    chk("R9 out ch15", ch_next_desc[15*32 +: 32], 32'hCAFE_F00D);

    // R10 buffer address read-only
    ch_cur_buf[9*32 +: 32] = 32'h0BAD_BEEF;
    wr(win(12'h130, 9), 32'h1111_1111);
    rd(win(12'h130, 9), r); chk("R10 reads input", r, 32'h0BAD_BEEF);

    // R11 semaphore
    wr(win(12'h140, 4), 32'hFFFF_FF02);
    wr(win(12'h140, 4), 32'h0000_0003);
    rd(win(12'h140, 4), r); chk("R11 add", r, 5);
    wr(win(12'h140, 4), 32'h0000_00FA);
    rd(win(12'h140, 4), r); chk("R11 saturate", r, 255);
    pulse(3, 16'h0010);
    chk("R11 dec", 32'(ch_sem_count[4*8 +: 8]), 254);
    pulse(3, 16'h0002);
    chk("R11 floor", 32'(ch_sem_count[1*8 +: 8]), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule